// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management master for a set of Ethernet PHYs. It sends one management frame at a time on the two-wire serial bus: a clock (`mdc`) and a bidirectional data line. Software reaches it through eight byte-wide registers. Registers 0 to 3 hold a 32-bit command word. Registers 4 to 7 hold a 32-bit status word. In both words the least significant byte sits at the lowest address.

Software first stages the data byte and the address fields. It then writes the top command byte with its launch flag (command bit 31) set. The block sends a read or write frame and clears the launch flag when the frame ends, so software polls that flag as a busy bit. On a read, the block checks that a PHY drives the line low in the second turnaround bit. If no PHY does, it reports a failed read and returns all ones as data. The line is driven through a separate output-enable signal so that a tri-state pad can be placed at chip level.

Top module: `mgmt_serial_master`

## Requirements
- R1: Command registers 0,1,2,3 read back bits 7:0, 15:8, 23:16 and 31:24 of the command word. Field layout: bit 31 = launch/busy flag, bit 26 = operation (1 write, 0 read), bits 25:21 = PHY address, bits 20:16 = register address, bits 15:0 = write data, and all other bits are writable but unused.
- R2: Status registers 4,5,6,7 read back bits 7:0, 15:8, 23:16 and 31:24 of the status word. Bit 31 = read failed, bits 15:0 = read data, and every other bit reads 0.
- R3: A frame starts only when register 3 is written with bit 7 set while the block is idle. Writes to registers 0 to 2, and a write to register 3 with bit 7 clear, start nothing, and `mdc` stays low.
- R4: Command bit 31 reads 1 from the launch write until the frame ends, then reads 0. Writes to the command registers during a frame are ignored.
- R5: Every frame has 64 bits, sent MSB first: 32 ones, start `01`, opcode (`10` for read, `01` for write), the 5-bit PHY address, the 5-bit register address, two turnaround bits, then 16 data bits.
- R6: In a write frame the master drives the line for all 64 bits. The turnaround bits are `10` and the data bits are command bits 15:0.
- R7: In a read frame the master releases the line (`mdioOe`=0) from the first turnaround bit to the end of the frame. The 16 bits sampled afterwards land in status bits 15:0 with failed=0.
- R8: If the line is high when the second turnaround bit of a read is sampled, status bit 31 becomes 1 and status bits 15:0 become 0xFFFF.
- R9: `mdc` is low when idle and has a period of 2*MDC_HALF system clocks during a frame. The master changes `mdioOut` only when `mdc` falls (or at launch) and samples the line on the rising `mdc` edge.
- R10: After reset, all eight registers read 0, `mdc` is low and `mdioOe` is low.
- R11: A write frame leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register select (0-3 command, 4-7 status) |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 8 | Write byte |
| regRdData | output | 8 | Read byte of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdioOut | output | 1 | Data value driven onto the line |
| mdioOe | output | 1 | Drive enable for the data line |
| mdioIn | input | 1 | Value seen on the data line |

## Verification
The hardest case to reach is the boundary between the master and the PHY owning the line during a read. The released first turnaround bit, the PHY's low second bit, and the failure path when nobody answers all fall within two `mdc` periods. The bench has a PHY model that counts rising `mdc` edges and drives the line from the falling edge that opens bit 47. Pull-up behaviour is modelled whenever neither side drives. The bench sweeps all 32 PHY addresses with reads and writes, and adds absent-PHY reads and command writes attempted while a frame is running.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = 46;   // index of first turnaround bit
  localparam int DATA_FIRST = 48;   // index of first data bit
  localparam int PRE_BITS   = 32;

  typedef struct packed {
    logic             launch;     // frame starts this cycle
    logic             busy;       // frame in progress
    logic             shiftNext;  // mdc falls, advance to next bit
    logic             sampleBit;  // mdc rises, line is sampled
    logic             finish;     // last falling edge of the frame
    logic [IDX_W-1:0] bitIdx;     // index of current bit in frame
  } seqStrobes_t;
endpackage

// File: rtl/mgmt_seq.sv
module mgmt_seq
  import mgmt_pkg::*;
#(
  parameter int MDC_HALF = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic        goBit,
  output logic        mdc,
  output seqStrobes_t strb
);
  localparam int CW = $clog2(MDC_HALF + 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(MDC_HALF - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic             busyQ, mdcQ;
  logic [CW-1:0]    divCnt;
  logic [IDX_W-1:0] bitCnt;
  logic             launch, tick, rise, fall, lastFall;

  assign launch   = regWrEn && (regAddr == 3'd3) && goBit && !busyQ;
  assign tick     = busyQ && (divCnt == DIV_LAST);
  assign rise     = tick && !mdcQ;
  assign fall     = tick && mdcQ;
  assign lastFall = fall && (bitCnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (launch) begin
      busyQ  <= 1'b1;
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busyQ) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (rise) mdcQ <= 1'b1;
      if (fall) begin
        mdcQ <= 1'b0;
        if (lastFall) busyQ <= 1'b0;
        else          bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign mdc = mdcQ;

  always_comb begin
    strb.launch    = launch;
    strb.busy      = busyQ;
    strb.shiftNext = fall && !lastFall;
    strb.sampleBit = rise;
    strb.finish    = lastFall;
    strb.bitIdx    = bitCnt;
  end

  // R9: the clock stays parked low whenever no frame is running
  a_r9_mdc_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !mdcQ);

  // R5: frame bits advance one at a time
  a_r5_bit_step: assert property (@(posedge clk) disable iff (!rstN)
    (fall && !lastFall) |=> (bitCnt == $past(bitCnt) + 1'b1));

  // R9: a rise is always followed by mdc high on the next cycle
  a_r9_rise_high: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> mdcQ);
endmodule

// File: rtl/mgmt_dpath.sv
module mgmt_dpath
  import mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t strb,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        mdioOe
);
  localparam logic [IDX_W-1:0] TA_PREV  = IDX_W'(TA_FIRST - 1);
  localparam logic [IDX_W-1:0] TA_LAST  = IDX_W'(TA_FIRST + 1);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_FIRST);

  logic [31:0]           cmdReg, statReg, launchCmd;
  logic [FRAME_BITS-1:0] txShift;
  logic [15:0]           rxShift;
  logic                  failQ, oeQ;
  logic                  cmdWr;

  function automatic logic [FRAME_BITS-1:0] buildFrame(input logic [31:0] c);
    logic isWr;
    isWr = c[26];
    return {{PRE_BITS{1'b1}}, 2'b01, (isWr ? 2'b01 : 2'b10), c[25:21], c[20:16],
            (isWr ? 2'b10 : 2'b11), (isWr ? c[15:0] : 16'hFFFF)};
  endfunction

  assign cmdWr     = regWrEn && !regAddr[2] && !strb.busy;
  assign launchCmd = {regWrData, cmdReg[23:0]};

  // command word: byte-staged, GO cleared at frame end
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (strb.finish) begin
      cmdReg[31] <= 1'b0;
    end else if (cmdWr) begin
      case (regAddr[1:0])
        2'd0: cmdReg[7:0]   <= regWrData;
        2'd1: cmdReg[15:8]  <= regWrData;
        2'd2: cmdReg[23:16] <= regWrData;
        default: cmdReg[31:24] <= regWrData;
      endcase
    end
  end

  // transmit shifter and drive enable, both move on mdc fall
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      oeQ     <= 1'b0;
    end else if (strb.launch) begin
      txShift <= buildFrame(launchCmd);
      oeQ     <= 1'b1;
    end else begin
      if (strb.shiftNext) txShift <= {txShift[FRAME_BITS-2:0], 1'b1};
      if (strb.finish)
        oeQ <= 1'b0;
      else if (strb.shiftNext && !cmdReg[26] && strb.bitIdx == TA_PREV)
        oeQ <= 1'b0;
    end
  end

  // receive side, sampled on mdc rise
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      failQ   <= 1'b0;
    end else if (strb.launch) begin
      rxShift <= '0;
      failQ   <= 1'b0;
    end else if (strb.sampleBit) begin
      if (strb.bitIdx == TA_LAST) failQ <= mdioIn;
      if (strb.bitIdx >= DATA_IDX) rxShift <= {rxShift[14:0], mdioIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0;
    end else if (strb.finish && !cmdReg[26]) begin
      statReg <= failQ ? {1'b1, 15'd0, 16'hFFFF} : {16'd0, rxShift};
    end
  end

  always_comb begin
    case (regAddr)
      3'd0: regRdData = cmdReg[7:0];
      3'd1: regRdData = cmdReg[15:8];
      3'd2: regRdData = cmdReg[23:16];
      3'd3: regRdData = cmdReg[31:24];
      3'd4: regRdData = statReg[7:0];
      3'd5: regRdData = statReg[15:8];
      3'd6: regRdData = statReg[23:16];
      default: regRdData = statReg[31:24];
    endcase
  end

  assign mdioOut = txShift[FRAME_BITS-1];
  assign mdioOe  = oeQ;

  // R4: busy from the sequencer implies GO visible in the command word
  a_r4_busy_go: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |-> cmdReg[31]);

  // R9: output moves only on launch or mdc fall
  a_r9_out_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.launch || strb.shiftNext) |=> $stable(mdioOut));

  // R7: line released from turnaround onward in a read
  a_r7_read_released: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !cmdReg[26] && strb.bitIdx >= IDX_W'(TA_FIRST)) |-> !mdioOe);

  // R8: a failed read always carries all-ones data
  a_r8_fail_data: assert property (@(posedge clk) disable iff (!rstN)
    statReg[31] |-> (statReg[15:0] == 16'hFFFF));
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
  import mgmt_pkg::*;
#(
  parameter int MDC_HALF = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       mdc,
  output logic       mdioOut,
  output logic       mdioOe,
  input  logic       mdioIn
);
  seqStrobes_t strb;

  mgmt_seq #(.MDC_HALF(MDC_HALF)) uSeq (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .goBit(regWrData[7]), .mdc(mdc), .strb(strb)
  );

  mgmt_dpath uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: tb/tb_mgmt_serial_master.sv
`timescale 1ns/1ps
module tb_mgmt_serial_master;
  localparam int HALF = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic mdc, mdioOut, mdioOe, mdioIn;

  int checks = 0, errors = 0;

  // PHY model state
  logic phyPresent = 1'b0, phyDrive = 1'b0, phyBit = 1'b1;
  logic [15:0] phyData = '0;
  logic [63:0] capFrame = '0, oeTrace = '0;
  int riseCnt = 0, cyc = 0, lastRise = -1, badPeriod = 0, conflict = 0;

  always #10 clk = ~clk;

  assign mdioIn = mdioOe ? mdioOut : (phyDrive ? phyBit : 1'b1);

  mgmt_serial_master #(.MDC_HALF(HALF)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mdioOe && phyDrive) conflict = conflict + 1;
  end

  always @(posedge mdc) begin
    capFrame = {capFrame[62:0], mdioIn};
    oeTrace  = {oeTrace[62:0], mdioOe};
    if (lastRise >= 0 && riseCnt > 0 && (cyc - lastRise) != 2 * HALF) badPeriod = badPeriod + 1;
    lastRise = cyc;
    riseCnt  = riseCnt + 1;
  end

  always @(negedge mdc) begin
    if (phyPresent && riseCnt == 47) begin
      phyDrive = 1'b1; phyBit = 1'b0;
    end else if (phyPresent && riseCnt >= 48 && riseCnt <= 63) begin
      phyBit = phyData[63 - riseCnt];
    end else begin
      phyDrive = 1'b0; phyBit = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic readWord(input logic [2:0] base, output logic [31:0] w);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      regRead(base + 3'(i), b);
      w[8*i +: 8] = b;
    end
  endtask

  task automatic runTxn(input logic [4:0] phy, input logic [4:0] rg, input bit wr,
                        input logic [15:0] data, input bit present, input bit tryBusyWr);
    logic [7:0] b;
    logic [31:0] st0, st1, cmd;
    logic [63:0] expFrame;
    int guard;
    readWord(3'd4, st0);
    phyPresent = present && !wr;
    phyData = ~data;
    riseCnt = 0; lastRise = -1;
    regWrite(3'd0, data[7:0]);
    regWrite(3'd1, data[15:8]);
    regWrite(3'd2, {phy[2:0], rg});
    regWrite(3'd3, {1'b1, 4'b0, wr, phy[4:3]});
    regRead(3'd3, b);
    check(b[7] == 1'b1, "R4 GO reads 1 while busy", 64'(b), 64'(b | 8'h80));
    if (tryBusyWr) begin
      regWrite(3'd0, ~data[7:0]);
      regWrite(3'd2, 8'h00);
    end
    guard = 0;
    do begin regRead(3'd3, b); guard++; end while (b[7] && guard < 5000);
    check(b[7] == 1'b0, "R4 GO cleared at frame end", 64'(b[7]), 64'd0);
    check(riseCnt == 64, "R5 frame length in mdc rises", 64'(riseCnt), 64'd64);
    if (wr)
      expFrame = {32'hFFFFFFFF, 2'b01, 2'b01, phy, rg, 2'b10, data};
    else if (present)
      expFrame = {32'hFFFFFFFF, 2'b01, 2'b10, phy, rg, 2'b10, ~data};
    else
      expFrame = {32'hFFFFFFFF, 2'b01, 2'b10, phy, rg, 2'b11, 16'hFFFF};
    check(capFrame == expFrame, wr ? "R6 write frame on line" : "R5 read frame on line", capFrame, expFrame);
    if (wr)
      check(oeTrace == '1, "R6 driven whole write", oeTrace, '1);
    else
      check(oeTrace == {{46{1'b1}}, 18'd0}, "R7 released from turnaround", oeTrace, {{46{1'b1}}, 18'd0});
    readWord(3'd0, cmd);
    check(cmd == {8'(wr) << 2 | 8'(phy[4:3]), phy[2:0], rg, data}, "R1 command readback",
          64'(cmd), 64'({8'(wr) << 2 | 8'(phy[4:3]), phy[2:0], rg, data}));
    readWord(3'd4, st1);
    if (wr)
      check(st1 == st0, "R11 status kept by write", 64'(st1), 64'(st0));
    else if (present)
      check(st1 == {16'd0, ~data}, "R7 read data in status", 64'(st1), 64'({16'd0, ~data}));
    else
      check(st1 == 32'h8000FFFF, "R8 absent PHY fail", 64'(st1), 64'h8000FFFF);
    phyPresent = 1'b0;
  endtask

  initial begin
    #(20.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    readWord(3'd0, w);
    check(w == 0, "R10 command reset", 64'(w), 0);
    readWord(3'd4, w);
    check(w == 0, "R10 status reset", 64'(w), 0);
    check(!mdc && !mdioOe, "R10 mdc/oe low", {62'd0, mdc, mdioOe}, 0);

    // R3 staging writes do not launch
    riseCnt = 0;
    regWrite(3'd0, 8'hFF);
    regWrite(3'd1, 8'h80);
    regWrite(3'd2, 8'h80);
    regWrite(3'd3, 8'h7F);
    repeat (40) @(negedge clk);
    check(riseCnt == 0 && !mdc, "R3 no launch without GO", 64'(riseCnt), 0);
    readWord(3'd0, w);
    check(w == 32'h7F8080FF, "R1 byte order", 64'(w), 64'h7F8080FF);

    // absent PHY, then present read, then busy-write attempt
    runTxn(5'd9, 5'd1, 1'b0, 16'h1234, 1'b0, 1'b0);
    regRead(3'd7, b);
    check(b == 8'h80, "R2 status top byte fail bit", 64'(b), 64'h80);
    regRead(3'd6, b);
    check(b == 8'h00, "R2 unused status bits zero", 64'(b), 0);
    runTxn(5'd17, 5'd3, 1'b0, 16'h5AA5, 1'b1, 1'b1);
    runTxn(5'd4, 5'd30, 1'b1, 16'hC33C, 1'b0, 1'b1);

    // sweep every PHY address
    for (int p = 0; p < 32; p++) begin
      runTxn(5'(p), 5'((p * 7) % 32), 1'b0, 16'(p * 16'h0813) ^ 16'hA5C3, 1'b1, 1'b0);
      runTxn(5'(p), 5'(31 - p), 1'b1, ~16'(p * 16'h1111), 1'b0, 1'b0);
      if (p == 5 || p == 20) runTxn(5'(p), 5'(p), 1'b0, 16'h0F0F, 1'b0, 1'b0);
    end

    check(badPeriod == 0, "R9 mdc period", 64'(badPeriod), 0);
    check(conflict == 0, "R7 no bus contention", 64'(conflict), 0);
    repeat (10) @(negedge clk);
    check(!mdc && !mdioOe, "R9 idle mdc low", {62'd0, mdc, mdioOe}, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule